// File: doc/BRIEF.md
# Cache Epoch Tracking Table

This block sits beside a cache controller and keeps, for every cache line, the coherence permission epoch the line currently holds. An epoch is either read-only or read-write. It is opened by a begin event carrying the line index, the epoch type and a block tag, and the current logical time becomes its start time. A later data-arrival event records a 16-bit hash of the block as it stood when the epoch started. Every local load and store is checked against the line's epoch, and an illegal access raises a one-cycle violation flag.

An epoch can end in three ways: a remote shared request (this ends read-write epochs only), a remote exclusive request, or an eviction. When it ends, the block queues an epoch report carrying the tag, the line, the type, the start and end times and the start and end hashes. The report leaves through a valid/ready output port.

Start times are 16 bits wide and can wrap. To cover this, each begin event also enters an ordered scrub queue. When the oldest open epoch comes within a guard band of wrapping, the block sends an open notice for it. When that epoch later ends, it sends a short closed notice in place of the full report.

Top module: `epoch_tracker`

## Requirements
- R1: After reset no line holds an epoch, `m_valid` is 0 and `viol` is 0.
- R2: A load to a line holding an epoch of either type gives `viol` = 0 in the cycle after the access.
- R3: A store to a read-only line, and any load or store to a line without an epoch, sets `viol` to 1 in the cycle after the access (and only then).
- R4: End cause 0 (remote shared) ends a read-write epoch and queues a report. On a read-only epoch it has no effect: the line stays readable and no message is queued.
- R5: End cause 1 (remote exclusive) and end cause 2 (eviction) end an epoch of either type. After that, accesses to the line violate (R3).
- R6: A report has `m_kind` = 0 and carries the tag, the line, the type (`m_rw` 1 = read-write), the start time (logical time at begin), the end time (logical time at end) and the start hash. `m_h1` is the `end_hash` input for a read-write epoch and 0 for a read-only one.
- R7: A begin event clears the start hash to 0. The first data arrival during the epoch sets it. Later arrivals, and arrivals to a line without an epoch, are ignored.
- R8: When the oldest tracked epoch is still open and `now_t - start` (mod 2^TW) reaches 2^TW - GUARD, an open notice is queued with `m_kind` = 1, tag, line, type, start time and start hash (`m_t1` = `m_h1` = 0). No notice is queued before that age.
- R9: When an epoch that already sent an open notice ends, the block queues a closed notice (`m_kind` = 2) carrying only the tag, the line and the end time. All other fields are 0.
- R10: Open notices follow begin order. Epochs that ended before reaching the scrub queue head produce no notice.
- R11: Messages leave in the order they were queued. The head message holds steady while `m_valid` is 1 and `m_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now_t | input | TW | Current logical time |
| beg_v | input | 1 | Epoch begin event |
| beg_idx | input | IW | Line of the begin event |
| beg_rw | input | 1 | 1 = read-write epoch, 0 = read-only |
| beg_tag | input | TAGW | Block tag of the line |
| dat_v | input | 1 | Data arrival event |
| dat_idx | input | IW | Line receiving data |
| dat_hash | input | HW | Hash of the arrived block |
| acc_v | input | 1 | Local access |
| acc_idx | input | IW | Line accessed |
| acc_st | input | 1 | 1 = store, 0 = load |
| end_v | input | 1 | Epoch end event |
| end_idx | input | IW | Line of the end event |
| end_cause | input | 2 | 0 remote shared, 1 remote exclusive, 2 eviction, 3 none |
| end_hash | input | HW | Block hash at the end of the epoch |
| viol | output | 1 | Access violation, one cycle after the access |
| m_valid | output | 1 | Message available |
| m_ready | input | 1 | Consumer takes the message |
| m_kind | output | 2 | 0 report, 1 open notice, 2 closed notice |
| m_tag | output | TAGW | Block tag |
| m_idx | output | IW | Line index |
| m_rw | output | 1 | Epoch type |
| m_t0 | output | TW | Start time |
| m_t1 | output | TW | End time |
| m_h0 | output | HW | Start hash |
| m_h1 | output | HW | End hash |

## Verification
The access check is driven from a table that crosses load and store with a read-only line, a read-write line and lines that never opened an epoch. This separates the type rule from the "no epoch" rule. The end causes are applied to both epoch types, which shows that a remote shared request ends only read-write epochs. Reports are compared field by field, including a line that never received data (start hash 0) and a line that received a second, ignored hash.

Jumping the logical time to one below and then exactly at the guard limit pins the age at which a notice fires. An ended epoch placed between two live ones shows that stale scrub entries are skipped and that notices follow begin order. A stalled consumer shows that queued messages stay stable and leave in order.

// File: rtl/epoch_tracker.sv
module epoch_tracker #(
  parameter int LINES    = 16,
  parameter int TW       = 16,
  parameter int HW       = 16,
  parameter int TAGW     = 20,
  parameter int WQ_DEPTH = 128,
  parameter int MQ_DEPTH = 4,
  parameter int GUARD    = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TW-1:0]   now_t,
  input  logic            beg_v,
  input  logic [$clog2(LINES)-1:0] beg_idx,
  input  logic            beg_rw,
  input  logic [TAGW-1:0] beg_tag,
  input  logic            dat_v,
  input  logic [$clog2(LINES)-1:0] dat_idx,
  input  logic [HW-1:0]   dat_hash,
  input  logic            acc_v,
  input  logic [$clog2(LINES)-1:0] acc_idx,
  input  logic            acc_st,
  input  logic            end_v,
  input  logic [$clog2(LINES)-1:0] end_idx,
  input  logic [1:0]      end_cause,
  input  logic [HW-1:0]   end_hash,
  output logic            viol,
  output logic            m_valid,
  input  logic            m_ready,
  output logic [1:0]      m_kind,
  output logic [TAGW-1:0] m_tag,
  output logic [$clog2(LINES)-1:0] m_idx,
  output logic            m_rw,
  output logic [TW-1:0]   m_t0,
  output logic [TW-1:0]   m_t1,
  output logic [HW-1:0]   m_h0,
  output logic [HW-1:0]   m_h1
);
  localparam int IW    = $clog2(LINES);
  localparam int WPW   = $clog2(WQ_DEPTH);
  localparam int MPW   = $clog2(MQ_DEPTH);
  localparam int MSGW  = 2 + TAGW + IW + 1 + 2*TW + 2*HW;
  localparam logic [TW:0] LIMIT = (TW+1)'((1 << TW) - GUARD);

  logic [LINES-1:0] vld, rw, rdy, ntc;
  logic [TW-1:0]    t0  [LINES];
  logic [HW-1:0]    h0  [LINES];
  logic [TAGW-1:0]  tag [LINES];

  logic [IW-1:0]  wq_idx [WQ_DEPTH];
  logic [TW-1:0]  wq_t   [WQ_DEPTH];
  logic [WPW-1:0] wq_rd, wq_wr;
  logic [WPW:0]   wq_cnt;

  logic [MSGW-1:0] mq [MQ_DEPTH];
  logic [MPW-1:0]  mq_rd, mq_wr;
  logic [MPW:0]    mq_cnt;

  logic [IW-1:0] hi;
  logic [TW-1:0] age;
  logic end_hit, head_live, ntc_fire, wq_pop, wq_push, mq_full, mq_pop, mq_push;
  logic [MSGW-1:0] end_msg, ntc_msg;

  assign end_hit = end_v && vld[end_idx] &&
                   (end_cause == 2'd1 || end_cause == 2'd2 || (end_cause == 2'd0 && rw[end_idx]));
  assign end_msg = ntc[end_idx] ?
      {2'd2, tag[end_idx], end_idx, 1'b0, {TW{1'b0}}, now_t, {HW{1'b0}}, {HW{1'b0}}} :
      {2'd0, tag[end_idx], end_idx, rw[end_idx], t0[end_idx], now_t, h0[end_idx],
       rw[end_idx] ? end_hash : {HW{1'b0}}};

  assign hi        = wq_idx[wq_rd];
  assign age       = now_t - wq_t[wq_rd];
  assign head_live = (wq_cnt != 0) && vld[hi] && !ntc[hi] && (t0[hi] == wq_t[wq_rd]);
  assign mq_full   = (mq_cnt == (MPW+1)'(MQ_DEPTH));
  assign ntc_fire  = head_live && ({1'b0, age} >= LIMIT) && !end_hit && !mq_full;
  assign ntc_msg   = {2'd1, tag[hi], hi, rw[hi], t0[hi], {TW{1'b0}}, h0[hi], {HW{1'b0}}};
  assign wq_pop    = (wq_cnt != 0) && (!head_live || ntc_fire);
  assign wq_push   = beg_v && (wq_cnt != (WPW+1)'(WQ_DEPTH) || wq_pop);

  assign m_valid = (mq_cnt != 0);
  assign mq_pop  = m_valid && m_ready;
  assign mq_push = end_hit || ntc_fire;
  assign {m_kind, m_tag, m_idx, m_rw, m_t0, m_t1, m_h0, m_h1} = mq[mq_rd];

  function automatic logic [WPW-1:0] wq_nx(input logic [WPW-1:0] p);
    return (p == WPW'(WQ_DEPTH-1)) ? '0 : p + 1'b1;
  endfunction
  function automatic logic [MPW-1:0] mq_nx(input logic [MPW-1:0] p);
    return (p == MPW'(MQ_DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0; rdy <= '0; ntc <= '0; rw <= '0; viol <= 1'b0;
    end else begin
      viol <= acc_v && (!vld[acc_idx] || (acc_st && !rw[acc_idx]));
      if (dat_v && vld[dat_idx] && !rdy[dat_idx]) begin
        rdy[dat_idx] <= 1'b1;
        h0[dat_idx]  <= dat_hash;
      end
      if (ntc_fire) ntc[hi] <= 1'b1;
      if (end_hit) vld[end_idx] <= 1'b0;
      if (beg_v) begin
        vld[beg_idx] <= 1'b1;
        rw[beg_idx]  <= beg_rw;
        rdy[beg_idx] <= 1'b0;
        ntc[beg_idx] <= 1'b0;
        t0[beg_idx]  <= now_t;
        h0[beg_idx]  <= '0;
        tag[beg_idx] <= beg_tag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wq_rd <= '0; wq_wr <= '0; wq_cnt <= '0;
    end else begin
      if (wq_push) begin
        wq_idx[wq_wr] <= beg_idx;
        wq_t[wq_wr]   <= now_t;
        wq_wr <= wq_nx(wq_wr);
      end
      if (wq_pop) wq_rd <= wq_nx(wq_rd);
      wq_cnt <= wq_cnt + (WPW+1)'(wq_push) - (WPW+1)'(wq_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mq_rd <= '0; mq_wr <= '0; mq_cnt <= '0;
    end else begin
      if (mq_push && (!mq_full || mq_pop)) begin
        mq[mq_wr] <= end_hit ? end_msg : ntc_msg;
        mq_wr <= mq_nx(mq_wr);
      end
      if (mq_pop) mq_rd <= mq_nx(mq_rd);
      mq_cnt <= mq_cnt + (MPW+1)'(mq_push && (!mq_full || mq_pop)) - (MPW+1)'(mq_pop);
    end
  end

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    end_hit |-> (!mq_full || mq_pop));
  assert_msg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable({m_kind, m_tag, m_idx, m_rw, m_t0, m_t1, m_h0, m_h1})));
  assert_viol_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> $past(acc_v));
  assert_store_ro_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_v && acc_st && vld[acc_idx] && !rw[acc_idx]) |=> viol);
  assert_load_ok_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_v && !acc_st && vld[acc_idx]) |=> !viol);
  assert_notice_kind_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (end_hit && ntc[end_idx]) |=> (m_valid));
endmodule

// File: tb/epoch_tracker_tb.sv
module epoch_tracker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 16, HW = 16, TAGW = 20, IW = 4;

  logic clk = 0, rst_n = 0;
  logic [TW-1:0] now_t = 0;
  logic beg_v = 0, beg_rw = 0, dat_v = 0, acc_v = 0, acc_st = 0, end_v = 0, m_ready = 0;
  logic [IW-1:0] beg_idx = 0, dat_idx = 0, acc_idx = 0, end_idx = 0;
  logic [TAGW-1:0] beg_tag = 0;
  logic [HW-1:0] dat_hash = 0, end_hash = 0;
  logic [1:0] end_cause = 0;
  logic viol, m_valid, m_rw;
  logic [1:0] m_kind;
  logic [TAGW-1:0] m_tag;
  logic [IW-1:0] m_idx;
  logic [TW-1:0] m_t0, m_t1;
  logic [HW-1:0] m_h0, m_h1;

  int tests = 0, fails = 0;

  epoch_tracker u_dut (.clk, .rst_n, .now_t, .beg_v, .beg_idx, .beg_rw, .beg_tag,
    .dat_v, .dat_idx, .dat_hash, .acc_v, .acc_idx, .acc_st, .end_v, .end_idx,
    .end_cause, .end_hash, .viol, .m_valid, .m_ready, .m_kind, .m_tag, .m_idx,
    .m_rw, .m_t0, .m_t1, .m_h0, .m_h1);

  always #(CLK_PERIOD/2) clk = ~clk;

  // {line[3:0], store, expected viol}
  localparam logic [5:0] VEC [8] = '{
    {4'd0, 1'b0, 1'b0}, {4'd0, 1'b1, 1'b1}, {4'd1, 1'b0, 1'b0}, {4'd1, 1'b1, 1'b0},
    {4'd2, 1'b0, 1'b1}, {4'd2, 1'b1, 1'b1}, {4'd9, 1'b0, 1'b1}, {4'd1, 1'b0, 1'b0}};

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic begin_ep(input int idx, input logic isrw, input logic [TAGW-1:0] tg);
    beg_v = 1; beg_idx = IW'(idx); beg_rw = isrw; beg_tag = tg; tick(); beg_v = 0;
  endtask
  task automatic data_ep(input int idx, input logic [HW-1:0] h);
    dat_v = 1; dat_idx = IW'(idx); dat_hash = h; tick(); dat_v = 0;
  endtask
  task automatic end_ep(input int idx, input logic [1:0] c, input logic [HW-1:0] h);
    end_v = 1; end_idx = IW'(idx); end_cause = c; end_hash = h; tick(); end_v = 0;
  endtask
  task automatic access(input int idx, input logic st, input logic exp, input string req);
    acc_v = 1; acc_idx = IW'(idx); acc_st = st; tick(); acc_v = 0;
    chk(viol == exp, req, 128'(viol), 128'(exp));
  endtask
  task automatic expect_msg(input logic [1:0] k, input logic [TAGW-1:0] tg, input int idx,
                            input logic r, input logic [TW-1:0] a, input logic [TW-1:0] b,
                            input logic [HW-1:0] c, input logic [HW-1:0] d, input string req);
    logic [127:0] act, exp;
    act = {m_valid, m_kind, m_tag, m_idx, m_rw, m_t0, m_t1, m_h0, m_h1};
    exp = {1'b1, k, tg, IW'(idx), r, a, b, c, d};
    chk(act == exp, req, act, exp);
    m_ready = 1; tick(); m_ready = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    // R1 reset state
    chk(m_valid == 0 && viol == 0, "R1 reset outputs", 128'({m_valid, viol}), 0);
    access(5, 0, 1, "R1 no epoch after reset");

    now_t = 10;
    begin_ep(0, 0, 20'hA0);
    begin_ep(1, 1, 20'hB1);
    data_ep(0, 16'h1111);
    data_ep(1, 16'h2222);
    data_ep(1, 16'h3333);   // R7 second arrival ignored
    data_ep(2, 16'h4444);   // R7 no epoch, ignored
    // R2 / R3 table
    for (int i = 0; i < 8; i++)
      access(int'(VEC[i][5:2]), VEC[i][1], VEC[i][0], "R2/R3 access table");

    // R4 remote shared on read-only: no effect
    now_t = 20;
    end_ep(0, 2'd0, 16'h0);
    tick();
    chk(m_valid == 0, "R4 RO shared no message", 128'(m_valid), 0);
    access(0, 0, 0, "R4 RO still readable");
    // R4/R6/R7 remote shared ends read-write
    end_ep(1, 2'd0, 16'h5555);
    expect_msg(2'd0, 20'hB1, 1, 1, 10, 20, 16'h2222, 16'h5555, "R6 R7 RW report");
    access(1, 1, 1, "R5 store after RW end");
    // R5 eviction of RO, R6 end hash zero
    now_t = 30;
    end_ep(0, 2'd2, 16'h9999);
    expect_msg(2'd0, 20'hA0, 0, 0, 10, 30, 16'h1111, 16'h0, "R6 RO report");
    access(0, 0, 1, "R5 load after evict");
    // R5 exclusive, R7 no data -> zero hash
    now_t = 40; begin_ep(3, 1, 20'hC3);
    now_t = 50; end_ep(3, 2'd1, 16'h7777);
    expect_msg(2'd0, 20'hC3, 3, 1, 40, 50, 16'h0, 16'h7777, "R5 R7 exclusive report");

    // R8/R10 scrub notices
    now_t = 100; begin_ep(4, 0, 20'hC4); data_ep(4, 16'hABCD);
    now_t = 150; begin_ep(6, 1, 20'hE6);
    now_t = 160; end_ep(6, 2'd2, 16'h0);
    expect_msg(2'd0, 20'hE6, 6, 1, 150, 160, 16'h0, 16'h0, "R6 line6 report");
    now_t = 200; begin_ep(5, 1, 20'hD5); data_ep(5, 16'h1234);
    repeat (4) tick();
    now_t = 16'd65379;
    repeat (3) tick();
    chk(m_valid == 0, "R8 no notice below limit", 128'(m_valid), 0);
    now_t = 16'd65380;
    repeat (2) tick();
    expect_msg(2'd1, 20'hC4, 4, 0, 100, 0, 16'hABCD, 0, "R8 open notice line4");
    repeat (3) tick();
    chk(m_valid == 0, "R10 stale skipped, line5 not yet", 128'(m_valid), 0);
    now_t = 16'd65480;
    repeat (2) tick();
    expect_msg(2'd1, 20'hD5, 5, 1, 200, 0, 16'h1234, 0, "R10 open notice line5");
    // R9 closed notice
    now_t = 16'd65500;
    end_ep(4, 2'd2, 16'h0);
    expect_msg(2'd2, 20'hC4, 4, 0, 0, 16'd65500, 0, 0, "R9 closed notice");
    access(4, 0, 1, "R9 line ended");

    // R11 backpressure and order
    now_t = 300;
    begin_ep(7, 1, 20'h77); begin_ep(8, 0, 20'h88);
    now_t = 310; end_ep(7, 2'd2, 16'h00AA);
    now_t = 320; end_ep(8, 2'd1, 16'h00BB);
    repeat (2) tick();
    chk(m_valid && m_idx == 7, "R11 head held", 128'({m_valid, m_idx}), 128'({1'b1, 4'd7}));
    expect_msg(2'd0, 20'h77, 7, 1, 300, 310, 0, 16'h00AA, "R11 first out");
    expect_msg(2'd0, 20'h88, 8, 0, 300, 320, 0, 0, "R11 second out");
    chk(m_valid == 0, "R11 queue drained", 128'(m_valid), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule